// File: doc/BRIEF.md
# Programmable Chip-Select Window Decoder

This block turns a 24-bit bus address into one of four chip-select outputs. Each window has three settings: a byte-wide base register that holds address bits 23..16, a byte-wide size-mask register and an enable bit. For each window the address is compared with the base only on the bits that the mask leaves in play. A mask bit of 1 takes its address bit, or its group of address bits, out of the compare, so the window grows.

The windows differ in how their eight mask bits land on address bits. Windows 0 and 1 have a fine low end, where one mask bit stands for a whole run of middle address bits. Windows 2 and 3 map their mask bits one-for-one onto a higher band. When more than one enabled window matches, only the lowest-numbered window is selected. The chip-select outputs are captured on a bus-cycle strobe and held between strobes. Software programs the windows through a byte-wide register port with a combinational read path.

Top module: `csw_decoder`

## Requirements
- R1: After reset every base register reads 0xFF, every mask register reads 0xFF, the enable register reads 0x00 and all chip-selects are low.
- R2: Window w has its base register at offset 0xC8+2w and its mask register at 0xC9+2w. The enable register is at 0xD0, with bit w enabling window w; its bits 7..4 read as 0. All of these read back what was written. A read of any other offset returns 0x00, and a write to any other offset changes nothing.
- R3: A mask bit of 0 puts its address bits into the compare, and a mask bit of 1 drops them. Address bits 7..0 never take part in the compare. Address bits 15..8 are compared against zero.
- R4: In window 0, mask bit 0 governs address bit 8, mask bit 1 governs address bits 14..9 as one group, and mask bits 7..2 govern address bits 20..15. The window size therefore runs from 256 bytes to 2 Mbytes.
- R5: In window 1, mask bit 0 governs address bit 8, mask bit 1 governs address bits 15..9 as one group, and mask bits 7..2 govern address bits 21..16. The window size therefore runs from 256 bytes to 4 Mbytes.
- R6: In windows 2 and 3, mask bits 7..0 govern address bits 22..15, one bit each, and address bits 14..8 are always ignored. The window size therefore runs from 32 Kbytes to 8 Mbytes.
- R7: Address bits above a window's maskable range are always compared: bits 23..21 for window 0, bits 23..22 for window 1 and bit 23 for windows 2 and 3.
- R8: A window whose enable bit is 0 never drives its chip-select high.
- R9: When several enabled windows match, only the lowest-numbered one is selected, so at most one chip-select is high at any time.
- R10: A chip-select takes the decode result at a clock edge where the strobe is high, and keeps its value through edges where the strobe is low.
- R11: A register write is captured at the clock edge where the write strobe is high. A decode at that same edge still uses the old setting, and a decode at the next edge uses the new one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| bus_addr | input | 24 | Bus address to decode |
| bus_strobe | input | 1 | Bus-cycle strobe; the decode is captured when it is high |
| cs | output | 4 | Chip-select per window, active high, one-hot or zero |

## Verification
The bench puts an address one step past each window's edge. Mapping window 0's group bit onto window 1's range, or the reverse, turns one of these hits into a miss. So does counting bits 14..8 in the compare for windows 2 and 3. It sets each group mask bit alone and touches only that group, so a design that gave the group a single address bit would miss. Several enabled windows are made to overlap, to show that the lowest one wins and that no two selects are high at once. A write and a strobe are given in the same cycle to show that the old setting still decodes at that edge. The strobe is dropped while the address changes, to show that the selects hold.

// File: rtl/csw_pkg.sv
package csw_pkg;
  localparam int ADDR_W = 24;
  localparam int BYTE_W = 8;
  localparam int BASE_LSB = 16;

  typedef enum logic [1:0] {
    MAP_GROUP6 = 2'd0,
    MAP_GROUP7 = 2'd1,
    MAP_LINEAR = 2'd2
  } map_kind_e;

  function automatic map_kind_e kind_of(input int win);
    if (win == 0) return MAP_GROUP6;
    if (win == 1) return MAP_GROUP7;
    return MAP_LINEAR;
  endfunction

  // 1 = address bit left out of the compare
  function automatic logic [ADDR_W-1:0] ignore_vec(input map_kind_e k,
                                                   input logic [BYTE_W-1:0] m);
    logic [ADDR_W-1:0] v;
    v = '0;
    v[7:0] = 8'hFF;
    case (k)
      MAP_GROUP6: begin
        v[8]     = m[0];
        v[14:9]  = {6{m[1]}};
        v[20:15] = m[7:2];
      end
      MAP_GROUP7: begin
        v[8]     = m[0];
        v[15:9]  = {7{m[1]}};
        v[21:16] = m[7:2];
      end
      default: begin
        v[14:8]  = 7'h7F;
        v[22:15] = m;
      end
    endcase
    return v;
  endfunction

  function automatic logic [ADDR_W-1:0] base_vec(input logic [BYTE_W-1:0] b);
    return {b, {BASE_LSB{1'b0}}};
  endfunction
endpackage

// File: rtl/csw_regfile.sv
module csw_regfile
  import csw_pkg::*;
#(
  parameter int NWIN = 4,
  parameter logic [7:0] BASE_OFF = 8'hC8,
  parameter logic [7:0] EN_OFF = 8'hD0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr,
  input  logic [BYTE_W-1:0]          addr,
  input  logic [BYTE_W-1:0]          wdata,
  output logic [BYTE_W-1:0]          rdata,
  output logic [NWIN-1:0][BYTE_W-1:0] base_q,
  output logic [NWIN-1:0][BYTE_W-1:0] mask_q,
  output logic [NWIN-1:0]            en_q
);
  logic [NWIN-1:0] base_sel, mask_sel;
  logic            en_sel;

  assign en_sel = (addr == EN_OFF);

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    localparam logic [7:0] BOFF = BASE_OFF + 8'(2 * w);
    localparam logic [7:0] MOFF = BASE_OFF + 8'(2 * w + 1);
    assign base_sel[w] = (addr == BOFF);
    assign mask_sel[w] = (addr == MOFF);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[w] <= '1;
        mask_q[w] <= '1;
      end else begin
        if (wr && base_sel[w]) base_q[w] <= wdata;
        if (wr && mask_sel[w]) mask_q[w] <= wdata;
      end
    end

    assert_mask_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && mask_sel[w]) |=> (mask_q[w] == $past(wdata)));
    assert_base_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && base_sel[w]) |=> (base_q[w] == $past(wdata)));
    assert_mask_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && mask_sel[w]) |=> $stable(mask_q[w]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= '0;
    else if (wr && en_sel) en_q <= wdata[NWIN-1:0];
  end

  always_comb begin
    rdata = '0;
    for (int w = 0; w < NWIN; w++) begin
      if (base_sel[w]) rdata = base_q[w];
      if (mask_sel[w]) rdata = mask_q[w];
    end
    if (en_sel) rdata = BYTE_W'(en_q);
  end
endmodule

// File: rtl/csw_window_match.sv
module csw_window_match
  import csw_pkg::*;
#(
  parameter int WIN = 0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] base,
  input  logic [BYTE_W-1:0] mask,
  input  logic              en,
  output logic              hit
);
  localparam map_kind_e KIND = kind_of(WIN);
  logic [ADDR_W-1:0] diff, care;

  assign care = ~ignore_vec(KIND, mask);
  assign diff = addr ^ base_vec(base);
  assign hit  = en && ((diff & care) == '0);
endmodule

// File: rtl/csw_priority.sv
module csw_priority #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  always_comb begin
    gnt = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) gnt = N'(1) << i;
    end
  end

  always_comb begin
    assert_grant_onehot_R9: assert ($onehot0(gnt));
    assert_grant_subset_R9: assert ((gnt & ~req) == '0);
  end
endmodule

// File: rtl/csw_decoder.sv
module csw_decoder
  import csw_pkg::*;
#(
  parameter int NWIN = 4,
  parameter logic [7:0] BASE_OFF = 8'hC8,
  parameter logic [7:0] EN_OFF = 8'hD0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [BYTE_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_strobe,
  output logic [NWIN-1:0]   cs
);
  logic [NWIN-1:0][BYTE_W-1:0] base_q, mask_q;
  logic [NWIN-1:0]             en_q;
  logic [NWIN-1:0]             win_hit;
  logic [NWIN-1:0]             win_gnt;

  csw_regfile #(.NWIN(NWIN), .BASE_OFF(BASE_OFF), .EN_OFF(EN_OFF)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .base_q(base_q), .mask_q(mask_q), .en_q(en_q)
  );

  for (genvar w = 0; w < NWIN; w++) begin : g_match
    csw_window_match #(.WIN(w)) u_match (
      .addr(bus_addr), .base(base_q[w]), .mask(mask_q[w]), .en(en_q[w]),
      .hit(win_hit[w])
    );
  end

  csw_priority #(.N(NWIN)) u_prio (.req(win_hit), .gnt(win_gnt));

  always_ff @(posedge clk) begin
    if (!rst_n) cs <= '0;
    else if (bus_strobe) cs <= win_gnt;
  end

  assert_cs_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs));
  assert_cs_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_strobe |=> $stable(cs));
  assert_cs_enabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_strobe |=> ((cs & ~$past(en_q)) == '0));
  assert_cs_from_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_strobe |=> ((cs & ~$past(win_hit)) == '0));
endmodule

// File: tb/csw_decoder_test.sv
module csw_decoder_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0;
  logic [7:0]  reg_addr = 0;
  logic [7:0]  reg_wdata = 0;
  logic [7:0]  reg_rdata;
  logic [23:0] bus_addr = 0;
  logic        bus_strobe = 0;
  logic [3:0]  cs;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  csw_decoder uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_addr(bus_addr),
    .bus_strobe(bus_strobe), .cs(cs)
  );

  // reference model
  logic [7:0] m_base [4];
  logic [7:0] m_mask [4];
  logic [3:0] m_en;
  logic [3:0] m_cs;

  function automatic bit bit_ignored(int w, int b, logic [7:0] mk);
    if (b < 8) return 1;
    if (w == 0) begin
      if (b >= 21) return 0;
      if (b >= 15) return mk[b - 13];
      if (b >= 9) return mk[1];
      return mk[0];
    end else if (w == 1) begin
      if (b >= 22) return 0;
      if (b >= 16) return mk[b - 14];
      if (b >= 9) return mk[1];
      return mk[0];
    end
    if (b == 23) return 0;
    if (b >= 15) return mk[b - 15];
    return 1;
  endfunction

  function automatic logic [3:0] model_decode(logic [23:0] a);
    for (int w = 0; w < 4; w++) begin
      bit ok = m_en[w];
      for (int b = 0; b < 24; b++) begin
        bit bb = (b >= 16) ? m_base[w][b - 16] : 1'b0;
        if (!bit_ignored(w, b, m_mask[w]) && (a[b] != bb)) ok = 0;
      end
      if (ok) return 4'(1 << w);
    end
    return 4'b0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < 4; w++) begin m_base[w] <= 8'hFF; m_mask[w] <= 8'hFF; end
      m_en <= 0; m_cs <= 0;
    end else begin
      if (bus_strobe) m_cs <= model_decode(bus_addr);
      if (reg_wr) begin
        for (int w = 0; w < 4; w++) begin
          if (reg_addr == 8'(8'hC8 + 2*w)) m_base[w] <= reg_wdata;
          if (reg_addr == 8'(8'hC9 + 2*w)) m_mask[w] <= reg_wdata;
        end
        if (reg_addr == 8'hD0) m_en <= reg_wdata[3:0];
      end
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-cycle comparison with the model (R10 capture/hold, R9 priority)
  always @(negedge clk) begin
    cycles++;
    if (rst_n) chk(cs == m_cs, "R10 model compare", 32'(cs), 32'(m_cs));
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, logic [7:0] exp, string tag);
    @(negedge clk); reg_addr = a; #1;
    chk(reg_rdata == exp, tag, 32'(reg_rdata), 32'(exp));
  endtask

  task automatic look(logic [23:0] a, logic [3:0] exp, string tag);
    @(negedge clk); bus_addr = a; bus_strobe = 1;
    @(negedge clk); bus_strobe = 0;
    chk(cs == exp, tag, 32'(cs), 32'(exp));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(cs == 0, "R1 cs reset", 32'(cs), 0);
    rd(8'hC8, 8'hFF, "R1 base0 reset");
    rd(8'hCF, 8'hFF, "R1 mask3 reset");
    rd(8'hD0, 8'h00, "R1 enable reset");
    look(24'h000000, 4'b0000, "R8 all disabled");

    // register map
    wr(8'hCA, 8'h5A); rd(8'hCA, 8'h5A, "R2 base1 rw");
    wr(8'hCD, 8'h3C); rd(8'hCD, 8'h3C, "R2 mask2 rw");
    wr(8'hD0, 8'hFF); rd(8'hD0, 8'h0F, "R2 enable upper bits zero");
    wr(8'hC0, 8'h77); rd(8'hC0, 8'h00, "R2 unmapped read");
    rd(8'hD1, 8'h00, "R2 unmapped read D1");
    rd(8'hC8, 8'hFF, "R2 unmapped write no effect");

    // window 0 alone
    wr(8'hD0, 8'h01); wr(8'hC8, 8'h00);
    look(24'h1FFFFF, 4'b0001, "R4 w0 2MB top");
    look(24'h200000, 4'b0000, "R7 w0 bit21 compared");
    wr(8'hC9, 8'h00);
    look(24'h0000FF, 4'b0001, "R3 low byte ignored");
    look(24'h000100, 4'b0000, "R3 bit8 vs zero");
    wr(8'hC9, 8'h02);
    look(24'h007E00, 4'b0001, "R4 w0 group 14..9");
    look(24'h000100, 4'b0000, "R4 w0 bit8 kept");
    look(24'h008000, 4'b0000, "R4 w0 bit15 kept");
    wr(8'hC9, 8'h01);
    look(24'h000100, 4'b0001, "R4 w0 mask bit0 is bit8");

    // window 1 alone
    wr(8'hD0, 8'h02); wr(8'hCA, 8'h40); wr(8'hCB, 8'hFF);
    look(24'h7FFFFF, 4'b0010, "R5 w1 4MB top");
    look(24'h800000, 4'b0000, "R7 w1 bit23 compared");
    look(24'h3FFFFF, 4'b0000, "R7 w1 bit22 compared");
    wr(8'hCB, 8'h02);
    look(24'h40FE00, 4'b0010, "R5 w1 group 15..9");
    look(24'h410000, 4'b0000, "R5 w1 bit16 kept");

    // windows 2 and 3
    wr(8'hD0, 8'h04); wr(8'hCC, 8'h80); wr(8'hCD, 8'h00);
    look(24'h807FFF, 4'b0100, "R6 w2 32KB bits14..8 ignored");
    look(24'h808000, 4'b0000, "R6 w2 bit15 kept");
    wr(8'hCD, 8'hFF);
    look(24'hFFFFFF, 4'b0100, "R6 w2 8MB");
    look(24'h7FFFFF, 4'b0000, "R7 w2 bit23 compared");
    wr(8'hD0, 8'h08); wr(8'hCE, 8'h00); wr(8'hCF, 8'h01);
    look(24'h00FFFF, 4'b1000, "R6 w3 mask bit0 is bit15");
    look(24'h010000, 4'b0000, "R6 w3 bit16 kept");

    // priority
    for (int w = 0; w < 4; w++) begin wr(8'(8'hC8 + 2*w), 8'h00); wr(8'(8'hC9 + 2*w), 8'hFF); end
    wr(8'hD0, 8'h0F);
    look(24'h000000, 4'b0001, "R9 lowest wins");
    look(24'h300000, 4'b0010, "R9 w1 when w0 misses");
    wr(8'hD0, 8'h0E);
    look(24'h000000, 4'b0010, "R8 disabled w0 skipped");

    // hold without strobe
    @(negedge clk); bus_addr = 24'hFFFFFF;
    repeat (3) @(negedge clk);
    chk(cs == 4'b0010, "R10 hold without strobe", 32'(cs), 32'h2);

    // same-edge write and strobe
    @(negedge clk); reg_wr = 1; reg_addr = 8'hD0; reg_wdata = 8'h00;
    bus_addr = 24'h000000; bus_strobe = 1;
    @(negedge clk); reg_wr = 0;
    chk(cs == 4'b0010, "R11 old setting at write edge", 32'(cs), 32'h2);
    @(negedge clk); bus_strobe = 0;
    chk(cs == 4'b0000, "R11 new setting next edge", 32'(cs), 32'h0);

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule